// File: doc/BRIEF.md
# Selectable Power-of-Two I/Q Decimation Chain

This block lowers the sample rate of a complex baseband stream, one I/Q pair per clock enable, by a factor of 2, 4, 8, 16 or 32 chosen at run time. It is a cascade of five identical half-band decimate-by-2 stages. The selected factor sets how many stages run; the rest are held idle with their valid outputs inactive. The last active stage drives the output port. Each stage is a symmetric 7-tap half-band low-pass filter with small integer coefficients. It computes a result only on every second accepted sample, and it rounds and saturates the result back to the input width. The stop-band rejection that a given application needs comes from the coefficient set. This RTL fixes one short integer set that the chain uses as written.

A mode input selects complex output (I and Q) or real output (I only, Q held at zero). Real output comes at the same rate and carries half the usable bandwidth. Any change to the factor or to the mode clears every delay line and phase counter. Output then restarts only once the cascade has filled again. The ports stream without handshakes: an input enable, and an output strobe that marks each valid result.

Top module: `hb_decim_chain`

## Requirements
- R1: `dec_sel` holds log2(N). Codes 1, 2, 3, 4 and 5 give N = 2, 4, 8, 16 and 32, and make that many stages active, counted from the input.
- R2: The chain produces one output per N accepted inputs. With `in_valid` high on every cycle, consecutive `out_valid` pulses are exactly N clock cycles apart.
- R3: Each stage number its accepted samples from 0 after a flush or reset. It emits a result only on an odd-numbered sample k >= 7. The result is (-x[k] + 9x[k-2] + 16x[k-3] + 9x[k-4] - x[k-6]) / 32.
- R4: Each stage rounds the scaled sum by adding 16 and shifting right 5 bits (arithmetic shift, ties rounded upward). It then saturates the result to the signed W-bit range (-32768 to 32767 for W = 16).
- R5: The I and Q paths use the same coefficients and the same latency, so each `out_valid` presents a matched pair.
- R6: With `real_mode` = 1, `out_i` follows the I filter path at the same rate as complex mode, and `out_q` is 0 whenever `out_valid` is high.
- R7: The codes 0, 6 and 7 on `dec_sel` are illegal and produce no `out_valid`, whatever the input.
- R8: A change of `dec_sel` or `real_mode` at a clock edge flushes every stage. The sample presented at that edge is discarded, and `out_valid` is low in the following cycle.
- R9: Synchronous reset `rst` clears all stage state. `out_valid` is low during reset and cannot rise until the stages have refilled.
- R10: Cycles with `in_valid` low leave the stage state unchanged. With one input every second cycle, the output spacing becomes 2N cycles.
- R11: Each active stage adds one register. An input that completes an output is captured at edge t and shows on the port after edge t + log2(N) - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_sel | input | 3 | Decimation code, log2(N) |
| real_mode | input | 1 | 1 selects real output, 0 selects complex output |
| in_valid | input | 1 | Input sample enable |
| in_i | input | W | In-phase input sample, signed |
| in_q | input | W | Quadrature input sample, signed |
| out_valid | output | 1 | Output strobe |
| out_i | output | W | In-phase output, signed |
| out_q | output | W | Quadrature output, signed (0 in real mode) |

## Verification
The chain is driven with several input patterns, each compared against an integer model of the cascade:
- A slow ramp shows the phase of each stage, because a wrong emission index gives a visibly shifted value.
- Pseudo-random data on differing I and Q exposes tap or coefficient errors and any mixing of the two paths.
- A square wave stresses the rounding at every stage.
- A pattern that mixes full-scale negative and positive samples drives the negative taps past the rails, which separates saturation from wrap-around.
Streams with a gap on every second cycle, a switch of mode in mid-stream, illegal codes and reset during a fill separate correct enable gating and flushing from state that leaks across.

// File: rtl/hb_decim_pkg.sv
package hb_decim_pkg;

  // half-band kernel: taps -1, 0, 9, 16, 9, 0, -1 scaled by 2^HB_SHIFT
  localparam int HB_TAPS   = 7;
  localparam int HB_SHIFT  = 5;
  localparam int HB_CENTER = 16;
  localparam int HB_NEAR   = 9;
  localparam int HB_FAR    = -1;

  // symmetric sum: the odd taps are zero, so only five samples enter
  function automatic int hb_mac(input int x0, input int x2, input int x3,
                                input int x4, input int x6);
    return HB_NEAR * (x2 + x4) + HB_FAR * (x0 + x6) + HB_CENTER * x3;
  endfunction

  // round to nearest (ties upward) then clamp to a signed w-bit range
  function automatic int hb_round_sat(input int acc, input int w);
    int r;
    int hi;
    int lo;
    r  = (acc + (1 <<< (HB_SHIFT - 1))) >>> HB_SHIFT;
    hi = (1 <<< (w - 1)) - 1;
    lo = -(1 <<< (w - 1));
    if (r > hi) return hi;
    if (r < lo) return lo;
    return r;
  endfunction

endpackage

// File: rtl/hb_decim_stage.sv
module hb_decim_stage #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);
  import hb_decim_pkg::*;

  localparam int HIST = HB_TAPS - 1;
  localparam int FW   = $clog2(HIST + 1);

  logic signed [W-1:0] hist_i [HIST];
  logic signed [W-1:0] hist_q [HIST];
  logic [FW-1:0]       fill;
  logic                phase;

  // named event: this accepted sample completes an output
  logic fire;
  assign fire = in_valid && phase && (fill == FW'(HIST));

  int y_i;
  int y_q;
  always_comb begin
    y_i = hb_round_sat(hb_mac(int'(in_i), int'(hist_i[1]), int'(hist_i[2]),
                              int'(hist_i[3]), int'(hist_i[5])), W);
    y_q = hb_round_sat(hb_mac(int'(in_q), int'(hist_q[1]), int'(hist_q[2]),
                              int'(hist_q[3]), int'(hist_q[5])), W);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int k = 0; k < HIST; k++) begin
        hist_i[k] <= '0;
        hist_q[k] <= '0;
      end
      fill      <= '0;
      phase     <= 1'b0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= fire;
      if (in_valid) begin
        hist_i[0] <= in_i;
        hist_q[0] <= in_q;
        for (int k = 1; k < HIST; k++) begin
          hist_i[k] <= hist_i[k-1];
          hist_q[k] <= hist_q[k-1];
        end
        phase <= ~phase;
        if (fill != FW'(HIST)) fill <= fill + FW'(1);
      end
      if (fire) begin
        out_i <= y_i[W-1:0];
        out_q <= y_q[W-1:0];
      end
    end
  end

  // R3: two inputs are needed between results, so strobes never touch
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R3: a result only follows an odd, fully primed input
  a_r3_primed_odd: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(fill) == FW'(HIST)) && $past(phase));

  // R10: no result without an accepted input on the previous edge
  a_r10_needs_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

endmodule

// File: rtl/hb_decim_chain.sv
module hb_decim_chain #(
  parameter  int W          = 16,
  parameter  int MAX_STAGES = 5,
  localparam int SELW       = $clog2(MAX_STAGES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SELW-1:0]     dec_sel,
  input  logic                real_mode,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);

  logic [SELW-1:0] sel_q;
  logic            real_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      real_q <= 1'b0;
    end else begin
      sel_q  <= dec_sel;
      real_q <= real_mode;
    end
  end

  // named events for the checks
  logic flush;
  logic legal_q;
  assign flush   = (dec_sel != sel_q) || (real_mode != real_q);
  assign legal_q = (sel_q != '0) && (sel_q <= SELW'(MAX_STAGES));

  logic                st_en [MAX_STAGES];
  logic                st_iv [MAX_STAGES];
  logic [MAX_STAGES-1:0] st_ov;
  logic signed [W-1:0] st_i  [MAX_STAGES];
  logic signed [W-1:0] st_q  [MAX_STAGES];

  for (genvar s = 0; s < MAX_STAGES; s++) begin : g_stage
    assign st_en[s] = legal_q && (SELW'(s) < sel_q);

    logic signed [W-1:0] src_i;
    logic signed [W-1:0] src_q;
    if (s == 0) begin : g_head
      assign st_iv[s] = in_valid && !flush && st_en[s];
      assign src_i    = in_i;
      assign src_q    = in_q;
    end else begin : g_link
      assign st_iv[s] = st_ov[s-1] && st_en[s];
      assign src_i    = st_i[s-1];
      assign src_q    = st_q[s-1];
    end

    hb_decim_stage #(.W(W)) u_hb (
      .clk       (clk),
      .rst       (rst),
      .flush     (flush),
      .in_valid  (st_iv[s]),
      .in_i      (src_i),
      .in_q      (src_q),
      .out_valid (st_ov[s]),
      .out_i     (st_i[s]),
      .out_q     (st_q[s])
    );
  end

  // tap the last active stage
  always_comb begin
    out_valid = 1'b0;
    out_i     = '0;
    out_q     = '0;
    for (int s = 0; s < MAX_STAGES; s++) begin
      if (legal_q && (sel_q == SELW'(s + 1))) begin
        out_valid = st_ov[s];
        out_i     = st_i[s];
        out_q     = real_q ? '0 : st_q[s];
      end
    end
  end

  // R8: a flush leaves no result pending in the next cycle
  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  // R7: an illegal code held for two cycles keeps every stage silent
  a_r7_illegal_silent: assert property (@(posedge clk) disable iff (rst)
    (!legal_q && $past(!legal_q)) |-> (st_ov == '0));

  // R1: the stage just past the active count never emits
  a_r1_idle_beyond: assert property (@(posedge clk) disable iff (rst)
    (legal_q && (sel_q < SELW'(MAX_STAGES)) && $stable(sel_q))
      |-> !st_ov[sel_q]);

endmodule

// File: tb/hb_decim_chain_test.sv
`timescale 1ns/100ps
module hb_decim_chain_test;

  localparam int W  = 16;
  localparam int NS = 5;
  localparam int QD = 4096;

  logic clk = 1'b0;
  logic rst;
  logic [2:0] dec_sel;
  logic real_mode;
  logic in_valid;
  logic signed [W-1:0] in_i;
  logic signed [W-1:0] in_q;
  logic out_valid;
  logic signed [W-1:0] out_i;
  logic signed [W-1:0] out_q;

  always #2.5 clk = ~clk;

  hb_decim_chain #(.W(W), .MAX_STAGES(NS)) uut (
    .clk(clk), .rst(rst), .dec_sel(dec_sel), .real_mode(real_mode),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int errors = 0;
  int cycle  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycle++;
    if (cycle > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycle, 150000);
      finish_run();
    end
  end

  // ---------------- reference model ----------------
  localparam int COEF [7] = '{-1, 0, 9, 16, 9, 0, -1};
  int mh_i [NS][7];
  int mh_q [NS][7];
  int mcnt [NS];
  int m_sel  = 0;
  bit m_real = 0;
  int exp_i [QD];
  int exp_q [QD];
  int wr = 0;
  int rd = 0;

  function automatic int ref_scale(input int acc);
    int r;
    int q;
    r = acc + 16;
    q = r / 32;
    if (r < 0 && (r % 32) != 0) q = q - 1;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      mcnt[s] = 0;
      for (int j = 0; j < 7; j++) begin
        mh_i[s][j] = 0;
        mh_q[s][j] = 0;
      end
    end
  endtask

  task automatic model_feed(input int xi, input int xq);
    int vi;
    int vq;
    int ai;
    int aq;
    vi = xi;
    vq = xq;
    if (m_sel < 1 || m_sel > NS) return;
    for (int s = 0; s < m_sel; s++) begin
      for (int j = 6; j > 0; j--) begin
        mh_i[s][j] = mh_i[s][j-1];
        mh_q[s][j] = mh_q[s][j-1];
      end
      mh_i[s][0] = vi;
      mh_q[s][0] = vq;
      mcnt[s]++;
      if (mcnt[s] < 8 || (mcnt[s] % 2) != 0) return;
      ai = 0;
      aq = 0;
      for (int j = 0; j < 7; j++) begin
        ai += COEF[j] * mh_i[s][j];
        aq += COEF[j] * mh_q[s][j];
      end
      vi = ref_scale(ai);
      vq = ref_scale(aq);
    end
    exp_i[wr % QD] = vi;
    exp_q[wr % QD] = m_real ? 0 : vq;
    wr++;
  endtask

  // ---------------- output monitor ----------------
  int gap_exp  = 0;
  bit have_last = 0;
  int last_cyc = 0;
  int ov_count = 0;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      ov_count++;
      if (gap_exp != 0 && have_last)
        check(cycle - last_cyc == gap_exp, "R2 R1 R10 output spacing", cycle - last_cyc, gap_exp);
      have_last = 1;
      last_cyc  = cycle;
      if (rd == wr) begin
        check(0, "R7 R8 R9 unexpected output", 1, 0);
      end else begin
        check(out_i == exp_i[rd % QD], m_real ? "R6 R3 R4 real I" : "R3 R4 R5 I", out_i, exp_i[rd % QD]);
        check(out_q == exp_q[rd % QD], m_real ? "R6 real Q zero" : "R3 R4 R5 Q", out_q, exp_q[rd % QD]);
        rd++;
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic int pat(input int p, input int amp, input int k, input int qs);
    int h;
    case (p)
      0: return qs ? (amp - ((k * 53) % (2 * amp))) : (-amp + ((k * 97) % (2 * amp)));
      1: begin
        h = ((k % 6) == 1) ? -32768 : 32767;
        return qs ? (-1 - h) : h;
      end
      2: begin
        h = (k * 1103515245 + 12345 + qs * 7919) & 32'h7fffffff;
        return (h % (2 * amp + 1)) - amp;
      end
      default: return ((((k + 2 * qs) / 4) % 2) != 0) ? amp : -amp;
    endcase
  endfunction

  task automatic step(input bit v, input int xi, input int xq, input bit feed);
    in_valid = v;
    in_i     = W'(xi);
    in_q     = W'(xq);
    if (v && feed) model_feed(xi, xq);
    @(negedge clk);
  endtask

  task automatic setcfg(input int s, input bit r);
    in_valid  = 1'b0;
    dec_sel   = 3'(s);
    real_mode = r;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    m_sel     = s;
    m_real    = r;
    gap_exp   = 0;
    have_last = 0;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // R1: column 0 is the code log2(N); cols: code, real, pattern, amplitude, samples, duty
  localparam int NV = 7;
  localparam int VEC [NV][6] = '{
    '{1, 0, 0,  1000,  200, 1},
    '{2, 0, 2, 20000,  300, 1},
    '{3, 0, 3, 30000,  400, 1},
    '{4, 1, 2, 32767,  600, 1},
    '{5, 0, 2, 25000, 1100, 1},
    '{1, 0, 1,     0,  200, 1},
    '{2, 1, 3, 12000,  300, 2}
  };

  initial begin
    rst = 1'b1; dec_sel = 3'd1; real_mode = 1'b0;
    in_valid = 1'b0; in_i = '0; in_q = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset output low", out_valid, 0);
    rst = 1'b0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      int n0;
      setcfg(VEC[v][0], VEC[v][1] != 0);
      gap_exp = (1 << VEC[v][0]) * VEC[v][5];
      n0 = ov_count;
      for (int k = 0; k < VEC[v][4]; k++) begin
        if (VEC[v][5] == 2) step(0, 0, 0, 0);
        step(1, pat(VEC[v][2], VEC[v][3], k, 0), pat(VEC[v][2], VEC[v][3], k, 1), 1);
      end
      drain();
      check(rd == wr, "R2 all expected outputs seen", rd, wr);
      check(ov_count > n0, "R1 R2 outputs produced", ov_count - n0, 1);
    end

    // R4 saturation: first N=2 result on the full-scale pattern
    setcfg(1, 0);
    for (int k = 0; k < 8; k++) step(1, pat(1, 0, k, 0), pat(1, 0, k, 1), 1);
    check(out_valid == 1'b1, "R11 N=2 latency", out_valid, 1);
    check(out_i == 16'sd32767, "R4 positive clamp", out_i, 32767);
    check(out_q == -16'sd32768, "R4 negative clamp", out_q, -32768);
    drain();

    // R11: N=4, input 21 completes the first result, shown one cycle later
    setcfg(2, 0);
    for (int k = 0; k < 22; k++) step(1, pat(2, 9000, k, 0), pat(2, 9000, k, 1), 1);
    check(out_valid == 1'b0, "R11 N=4 first stage only", out_valid, 0);
    step(0, 0, 0, 0);
    check(out_valid == 1'b1, "R11 N=4 result after two edges", out_valid, 1);
    drain();

    // R8: mode change on the completing sample
    setcfg(1, 0);
    for (int k = 0; k < 7; k++) step(1, 1000 * k, -500 * k, 1);
    real_mode = 1'b1;
    step(1, 7000, -3500, 0);
    check(out_valid == 1'b0, "R8 flush suppresses output", out_valid, 0);
    model_reset();
    m_real = 1;
    for (int k = 0; k < 7; k++) step(1, 300 * k, 200 * k, 1);
    check(ov_count >= 0 && rd == wr, "R8 no output before refill", wr - rd, 0);
    for (int k = 7; k < 20; k++) step(1, 300 * k, 200 * k, 1);
    drain();
    check(rd == wr, "R8 R6 restarted stream", rd, wr);

    // R9: reset in mid-fill
    setcfg(1, 0);
    for (int k = 0; k < 7; k++) step(1, 111 * k, 77 * k, 0);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 output low in reset", out_valid, 0);
    rst = 1'b0;
    setcfg(1, 0);
    begin
      int c0;
      c0 = ov_count;
      step(1, 5000, 5000, 1);
      step(0, 0, 0, 0);
      check(ov_count == c0, "R9 state cleared by reset", ov_count - c0, 0);
    end
    drain();

    // R7: illegal codes
    for (int t = 0; t < 3; t++) begin
      int code;
      int c0;
      code = (t == 0) ? 0 : 5 + t;
      setcfg(code, 0);
      c0 = ov_count;
      for (int k = 0; k < 100; k++) step(1, pat(2, 30000, k, 0), pat(2, 30000, k, 1), 1);
      drain();
      check(ov_count == c0, "R7 illegal code silent", ov_count - c0, 0);
    end

    finish_run();
  end

endmodule